// File: doc/BRIEF.md
# Composite Memory Select Generator

This block merges the per-space memory strobes of a processor's external bus into one programmable chip-select. Four active-low strobes come in: program, data, boot and I/O. A small enable register holds one bit per strobe. The composite select goes low in every cycle in which at least one enabled strobe is low. A single physical memory can then answer to several address spaces, with one strobe used as an extra address bit where needed.

The same block also drives the individual strobes back out. Each passes through one register, so the composite and the individual outputs keep identical timing. A separate control bit suppresses the boot strobe at the output without touching the composite path. Booting can therefore come from one device while another device, reached through the composite select, serves transfers at run time. When the bus is granted to another master, every output is released high. Software reaches the two configuration words through a simple write port and a registered read port.

Top module: `cms_gen`

## Requirements
- R1: In the cycle after an input edge at which the bus is not granted away and at least one strobe whose enable bit is 1 is low, `cms_n_o` is 0.
- R2: In the cycle after an input edge at which no enabled strobe is low, `cms_n_o` is 1. Strobes with enable bit 0 have no effect on it.
- R3: Register address 0 holds the enables in bits [3:0]: bit 0 program, bit 1 data, bit 2 boot, bit 3 I/O. Register address 1 holds the boot-disable flag in bit 3. A write with `wr_en_i` high updates the addressed register at the clock edge. Other data bits are dropped and read back as 0.
- R4: After reset the enable word is 4'b1011 (every source on except boot), the boot-disable flag is 0, and all strobe outputs are high.
- R5: While the boot-disable flag is 1, `sel_n_o[2]` stays high. The other strobe outputs and `cms_n_o`, including a boot contribution to it, are unaffected.
- R6: In the cycle after an edge at which `bus_grant_i` is high, `cms_n_o` and every bit of `sel_n_o` are 1.
- R7: Each `sel_n_o` bit copies its `sel_n_i` bit with one cycle of latency, the same latency as `cms_n_o`.
- R8: `rd_data_o` shows the register selected by `rd_addr_i` one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 4 | Active-low strobes: [0] program, [1] data, [2] boot, [3] I/O |
| bus_grant_i | input | 1 | High while the bus is handed to another master |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address (0 enables, 1 control) |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 1 | Read address |
| rd_data_o | output | 16 | Registered read data |
| sel_n_o | output | 4 | Registered strobe outputs, boot strobe gated by the disable flag |
| cms_n_o | output | 1 | Registered active-low composite select |

## Verification
The bench builds the block with its defaults: four sources, 16-bit register words, the boot source at index 2 and its disable flag at bit 3. With only four sources, all 16 enable words can be crossed with all 16 strobe patterns in a few hundred cycles, and the bench does this. That sweep covers every merge case, including an all-disabled enable word and strobes from disabled sources. Directed scenarios then cover the boot gate with the boot source enabled and disabled, a bus grant arriving while strobes are active, and writes that carry stray upper bits.

// File: rtl/cms_pkg.sv
package cms_pkg;
  localparam int unsigned SRC_PROG = 0;
  localparam int unsigned SRC_DATA = 1;
  localparam int unsigned SRC_BOOT = 2;
  localparam int unsigned SRC_IO   = 3;

  typedef enum logic {
    REG_ENABLES = 1'b0,
    REG_CONTROL = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/cms_regs.sv
module cms_regs
  import cms_pkg::*;
#(
  parameter int unsigned N_SRC    = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned BDIS_BIT = 3,
  parameter logic [N_SRC-1:0] EN_RESET = 4'b1011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [N_SRC-1:0]  en_o,
  output logic              bdis_o
);
  logic [N_SRC-1:0]  en_q;
  logic              bdis_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (reg_sel_e'(rd_addr_i) == REG_ENABLES) rd_next[N_SRC-1:0] = en_q;
    else                                      rd_next[BDIS_BIT]   = bdis_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= EN_RESET;
      bdis_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      rd_q <= rd_next;
      if (wr_en_i) begin
        if (reg_sel_e'(wr_addr_i) == REG_ENABLES) en_q <= wr_data_i[N_SRC-1:0];
        else                                      bdis_q <= wr_data_i[BDIS_BIT];
      end
    end
  end

  assign en_o      = en_q;
  assign bdis_o    = bdis_q;
  assign rd_data_o = rd_q;

  assert_reset_defaults_R4: assert property (@(posedge clk)
    rst |=> (en_o == EN_RESET && !bdis_o));

  assert_enable_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i == 1'b0) |=> en_o == $past(wr_data_i[N_SRC-1:0]));

  assert_control_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i == 1'b1) |=> bdis_o == $past(wr_data_i[BDIS_BIT]));
endmodule

// File: rtl/cms_merge.sv
module cms_merge #(
  parameter int unsigned N_SRC    = 4,
  parameter int unsigned BOOT_IDX = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] sel_n_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             bdis_i,
  input  logic             grant_i,
  output logic [N_SRC-1:0] sel_n_o,
  output logic             cms_n_o
);
  logic [N_SRC-1:0] hit;
  logic [N_SRC-1:0] pass_n;
  logic [N_SRC-1:0] sel_q;
  logic             cms_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i] = en_i[i] & ~sel_n_i[i];
    if (i == BOOT_IDX) begin : g_boot
      assign pass_n[i] = sel_n_i[i] | bdis_i;
    end else begin : g_plain
      assign pass_n[i] = sel_n_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || grant_i) begin
      sel_q <= '1;
      cms_q <= 1'b1;
    end else begin
      sel_q <= pass_n;
      cms_q <= ~|hit;
    end
  end

  assign sel_n_o = sel_q;
  assign cms_n_o = cms_q;

  assert_cms_low_R1: assert property (@(posedge clk) disable iff (rst)
    (!grant_i && |(en_i & ~sel_n_i)) |=> !cms_n_o);

  assert_cms_high_R2: assert property (@(posedge clk) disable iff (rst)
    ((en_i & ~sel_n_i) == '0) |=> cms_n_o);

  assert_boot_gate_R5: assert property (@(posedge clk) disable iff (rst)
    bdis_i |=> sel_n_o[BOOT_IDX]);

  assert_grant_release_R6: assert property (@(posedge clk) disable iff (rst)
    grant_i |=> (cms_n_o && (&sel_n_o)));
endmodule

// File: rtl/cms_gen.sv
module cms_gen
  import cms_pkg::*;
#(
  parameter int unsigned N_SRC    = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned BDIS_BIT = 3,
  parameter logic [N_SRC-1:0] EN_RESET = 4'b1011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  sel_n_i,
  input  logic              bus_grant_i,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [N_SRC-1:0]  sel_n_o,
  output logic              cms_n_o
);
  localparam int unsigned BOOT_IDX = SRC_BOOT;

  logic [N_SRC-1:0] en_w;
  logic             bdis_w;

  cms_regs #(
    .N_SRC(N_SRC), .DATA_W(DATA_W), .BDIS_BIT(BDIS_BIT), .EN_RESET(EN_RESET)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .en_o(en_w), .bdis_o(bdis_w)
  );

  cms_merge #(
    .N_SRC(N_SRC), .BOOT_IDX(BOOT_IDX)
  ) u_merge (
    .clk(clk), .rst(rst),
    .sel_n_i(sel_n_i), .en_i(en_w), .bdis_i(bdis_w), .grant_i(bus_grant_i),
    .sel_n_o(sel_n_o), .cms_n_o(cms_n_o)
  );

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (!bus_grant_i && !bdis_w) |=> sel_n_o == $past(sel_n_i));
endmodule

// File: tb/sim_cms_gen.sv
module sim_cms_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  sel_n_i = 4'hF;
  logic        bus_grant_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_addr_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        rd_addr_i = 1'b0;
  logic [15:0] rd_data_o;
  logic [3:0]  sel_n_o;
  logic        cms_n_o;

  int errors = 0;
  int checks = 0;
  logic [3:0] en_m = 4'b1011;
  logic       bdis_m = 1'b0;

  always #4 clk = ~clk;

  cms_gen u0 (
    .clk(clk), .rst(rst), .sel_n_i(sel_n_i), .bus_grant_i(bus_grant_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .sel_n_o(sel_n_o), .cms_n_o(cms_n_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    tick();
    wr_en_i = 1'b0; wr_data_i = '0;
    if (a == 1'b0) en_m = d[3:0];
    else           bdis_m = d[3];
  endtask

  task automatic rd(input string req, input logic a);
    rd_addr_i = a;
    tick();
    chk(req, {16'h0, rd_data_o}, a ? {28'h0, bdis_m, 3'b000} : {28'h0, en_m});
  endtask

  function automatic logic exp_cms(input logic [3:0] s);
    return ~|(en_m & ~s);
  endfunction

  function automatic logic [3:0] exp_sel(input logic [3:0] s);
    logic [3:0] r = s;
    r[2] = s[2] | bdis_m;
    return r;
  endfunction

  task automatic t_reset();
    chk("R4 cms during reset", {31'h0, cms_n_o}, 32'h1);
    chk("R4 sel during reset", {28'h0, sel_n_o}, 32'hF);
    rst = 1'b0;
    rd("R4 R8 enable default", 1'b0);
    rd("R4 R8 control default", 1'b1);
  endtask

  task automatic t_sweep();
    for (int e = 0; e < 16; e++) begin
      wr(1'b0, 16'(e));
      for (int s = 0; s < 16; s++) begin
        sel_n_i = 4'(s);
        tick();
        chk("R1 R2 composite", {31'h0, cms_n_o}, {31'h0, exp_cms(4'(s))});
        chk("R7 pass-through", {28'h0, sel_n_o}, {28'h0, exp_sel(4'(s))});
      end
    end
    sel_n_i = 4'hF;
    tick();
  endtask

  task automatic t_regmap();
    wr(1'b0, 16'hFFF5);
    rd("R3 enable upper bits dropped", 1'b0);
    wr(1'b1, 16'hFFF7);
    rd("R3 control bit3 clear", 1'b1);
    wr(1'b1, 16'h0008);
    rd("R3 control bit3 set", 1'b1);
    wr(1'b1, 16'h0000);
    rd("R8 control readback", 1'b1);
  endtask

  task automatic t_boot_disable();
    wr(1'b0, 16'h0004);
    wr(1'b1, 16'h0008);
    sel_n_i = 4'b1011;
    tick();
    chk("R5 boot strobe gated", {28'h0, sel_n_o}, 32'hF);
    chk("R5 composite keeps boot", {31'h0, cms_n_o}, 32'h0);
    sel_n_i = 4'b0110;
    tick();
    chk("R5 others pass", {28'h0, sel_n_o}, 32'h6);
    wr(1'b1, 16'h0000);
    sel_n_i = 4'b1011;
    tick();
    chk("R5 boot strobe restored", {28'h0, sel_n_o}, 32'hB);
    sel_n_i = 4'hF;
    tick();
  endtask

  task automatic t_grant();
    wr(1'b0, 16'h000F);
    sel_n_i = 4'b0000;
    tick();
    chk("R1 all low", {31'h0, cms_n_o}, 32'h0);
    bus_grant_i = 1'b1;
    tick();
    chk("R6 cms released", {31'h0, cms_n_o}, 32'h1);
    chk("R6 sel released", {28'h0, sel_n_o}, 32'hF);
    bus_grant_i = 1'b0;
    tick();
    chk("R6 resume after grant", {31'h0, cms_n_o}, 32'h0);
    sel_n_i = 4'hF;
    tick();
    chk("R2 idle", {31'h0, cms_n_o}, 32'h1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    tick();
    tick();
    t_reset();
    t_sweep();
    t_regmap();
    t_boot_disable();
    t_grant();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule